// File: doc/BRIEF.md
# Byte-Wise Flash Word Program Sequencer

This block drives the control interface of a flash-style array whose cells can only change from 1 to 0. A single request asks for one 16-bit word to be written. The request carries a target address, the desired data and the data the array currently reads back at that address. From these the block works out which bits still have to be cleared. Because a pulse may touch at most eight bits, the word is written in two byte passes: the low byte first, then the high byte. A pass with nothing to program is skipped.

For each pass the sequencer first loads its address and data registers. It then writes the segment control word with the program mode and the enable of the segment that holds the address, and waits a supply-settling time. Next it raises the execute bit with its key pattern in one write, holds the pulse, clears the whole control word, and waits an array-recovery time. The three waits are parameters counted in clock cycles, each at least 1. A busy level and a one-cycle done pulse report progress.

Top module: `flash_word_prog`

## Requirements
- R1: While the execute bit (control bit 15) is set, at least one byte of `flashData` is 8'hFF, so no pulse programs more than eight bits.
- R2: A bit is marked for programming (written 0 in `flashData`) only where `readData` is 1 and `wantData` is 0. In the low pass the high byte of `flashData` is 8'hFF. In the high pass the low byte is 8'hFF.
- R3: The low pass runs before the high pass. A pass whose byte has no bit to program is skipped and issues no pulse. A request with no bit to program at all gives `done` in the cycle after acceptance, and `busy` never rises.
- R4: In the cycle after a request is accepted, `flashAddr` holds the target address, `flashData` holds the masked data and `ctrlWord` is still zero. The data loads again at the start of the high pass.
- R5: The control word then holds mode 2'b10 in bits [9:8] and a one-hot segment enable in bits [7:0]. The enable index is taken from the top three address bits. This value stays for exactly PGM_MODE_CYCLES cycles before the pulse starts.
- R6: The pulse sets bit 15 (execute) and bit 13 (key high), with bit 12 (key low) at 0, all in one cycle. The mode and enables keep their values. The pulse lasts exactly PGM_CYCLES cycles, and then the whole control word becomes 16'h0000.
- R7: After each pulse, the control word stays zero and `busy` stays high for exactly BUSY_CYCLES cycles before the next pass loads or `done` is given.
- R8: `busy` is high from the cycle after acceptance until `done`. `done` is a one-cycle pulse in the same cycle that `busy` falls.
- R9: A start request made while `busy` is high has no effect on the outputs.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to program a word, sampled only while idle |
| targetAddr | input | ADDR_W | Word address to program |
| wantData | input | 16 | Desired word value |
| readData | input | 16 | Current read-back value at the address |
| flashAddr | output | ADDR_W | Address register |
| flashData | output | 16 | Masked data register |
| ctrlWord | output | 16 | Segment control word (mode, enables, execute, keys) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `targetAddr`, `wantData` and `readData` are meaningful only in the cycle a request is accepted. They also assume that reset is applied before the first request. The pulse and clear checks rely on the control word being written only by this block. The stimulus changes inputs only away from the active edge. It deliberately keeps `startReq` high across busy periods and varies data between requests. This exercises the rule that only the accepting cycle matters, without ever violating the assumptions.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  localparam int DATA_W = 16;
  localparam int CTRL_W = 16;
  localparam int EXE_BIT = 15;
  localparam int KEYH_BIT = 13;
  localparam int KEYL_BIT = 12;
  localparam int MODE_LSB = 8;
  localparam logic [1:0] MODE_PROGRAM = 2'b10;

  typedef struct packed {
    logic capture;
    logic loadLo;
    logic loadHi;
    logic setMode;
    logic fire;
    logic clear;
  } strobe_t;
endpackage

// File: rtl/fwp_datapath.sv
module fwp_datapath
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEG_N = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [ADDR_W-1:0]   targetAddr,
  input  logic [DATA_W-1:0]   wantData,
  input  logic [DATA_W-1:0]   readData,
  output logic                inNeedLo,
  output logic                inNeedHi,
  output logic                keptNeedHi,
  output logic [ADDR_W-1:0]   flashAddr,
  output logic [DATA_W-1:0]   flashData,
  output logic [CTRL_W-1:0]   ctrlWord
);
  localparam int SEG_IDX_W = $clog2(SEG_N);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] needIn, keptNeed, needSel;
  logic [ADDR_W-1:0] keptAddr, addrSel;
  logic [SEG_N-1:0]  segOneHot, keptSeg;
  logic [SEG_IDX_W-1:0] segIdx;
  logic [CTRL_W-1:0] modeWord;

  assign needIn = readData & ~wantData;
  assign inNeedLo = |needIn[HALF_W-1:0];
  assign inNeedHi = |needIn[DATA_W-1:HALF_W];
  assign keptNeedHi = |keptNeed[DATA_W-1:HALF_W];
  assign needSel = stb.capture ? needIn : keptNeed;
  assign addrSel = stb.capture ? targetAddr : keptAddr;
  assign segIdx = targetAddr[ADDR_W-1 -: SEG_IDX_W];

  always_comb begin
    segOneHot = '0;
    segOneHot[segIdx] = 1'b1;
  end

  always_comb begin
    modeWord = '0;
    modeWord[MODE_LSB +: 2] = MODE_PROGRAM;
    for (int i = 0; i < SEG_N; i++) modeWord[i] = keptSeg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keptNeed <= '0;
      keptAddr <= '0;
      keptSeg <= '0;
    end else if (stb.capture) begin
      keptNeed <= needIn;
      keptAddr <= targetAddr;
      keptSeg <= segOneHot;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flashAddr <= '0;
      flashData <= '0;
    end else if (stb.loadLo) begin
      flashAddr <= addrSel;
      flashData <= {{HALF_W{1'b1}}, ~needSel[HALF_W-1:0]};
    end else if (stb.loadHi) begin
      flashAddr <= addrSel;
      flashData <= {~needSel[DATA_W-1:HALF_W], {HALF_W{1'b1}}};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord <= '0;
    end else if (stb.clear) begin
      ctrlWord <= '0;
    end else if (stb.setMode) begin
      ctrlWord <= modeWord;
    end else if (stb.fire) begin
      ctrlWord[EXE_BIT] <= 1'b1;
      ctrlWord[KEYH_BIT] <= 1'b1;
      ctrlWord[KEYL_BIT] <= 1'b0;
    end
  end
endmodule

// File: rtl/fwp_control.sv
module fwp_control
  import flash_prog_pkg::*;
#(
  parameter int PGM_MODE_CYCLES = 4,
  parameter int PGM_CYCLES = 8,
  parameter int BUSY_CYCLES = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    inNeedLo,
  input  logic    inNeedHi,
  input  logic    keptNeedHi,
  output strobe_t stb,
  output logic    busy,
  output logic    done
);
  localparam int MAX_WAIT = (PGM_MODE_CYCLES > PGM_CYCLES)
    ? ((PGM_MODE_CYCLES > BUSY_CYCLES) ? PGM_MODE_CYCLES : BUSY_CYCLES)
    : ((PGM_CYCLES > BUSY_CYCLES) ? PGM_CYCLES : BUSY_CYCLES);
  localparam int CNT_W = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] LAST_SETTLE = CNT_W'(PGM_MODE_CYCLES - 1);
  localparam logic [CNT_W-1:0] LAST_HOLD = CNT_W'(PGM_CYCLES - 1);
  localparam logic [CNT_W-1:0] LAST_RECOV = CNT_W'(BUSY_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE, S_MODE, S_SETTLE, S_HOLD, S_RECOV} state_t;

  state_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic onHi, onHiNext, doneNext;

  always_comb begin
    stb = '0;
    stateNext = state;
    cntNext = cnt + 1'b1;
    onHiNext = onHi;
    doneNext = 1'b0;
    case (state)
      S_IDLE: begin
        cntNext = '0;
        if (startReq) begin
          stb.capture = 1'b1;
          if (inNeedLo) begin
            stb.loadLo = 1'b1;
            onHiNext = 1'b0;
            stateNext = S_MODE;
          end else if (inNeedHi) begin
            stb.loadHi = 1'b1;
            onHiNext = 1'b1;
            stateNext = S_MODE;
          end else begin
            doneNext = 1'b1;
          end
        end
      end
      S_MODE: begin
        stb.setMode = 1'b1;
        cntNext = '0;
        stateNext = S_SETTLE;
      end
      S_SETTLE: if (cnt == LAST_SETTLE) begin
        stb.fire = 1'b1;
        cntNext = '0;
        stateNext = S_HOLD;
      end
      S_HOLD: if (cnt == LAST_HOLD) begin
        stb.clear = 1'b1;
        cntNext = '0;
        stateNext = S_RECOV;
      end
      S_RECOV: if (cnt == LAST_RECOV) begin
        cntNext = '0;
        if (!onHi && keptNeedHi) begin
          stb.loadHi = 1'b1;
          onHiNext = 1'b1;
          stateNext = S_MODE;
        end else begin
          doneNext = 1'b1;
          stateNext = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt <= '0;
      onHi <= 1'b0;
      done <= 1'b0;
    end else begin
      state <= stateNext;
      cnt <= cntNext;
      onHi <= onHiNext;
      done <= doneNext;
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/flash_word_prog.sv
module flash_word_prog
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEG_N = 8,
  parameter int PGM_MODE_CYCLES = 4,
  parameter int PGM_CYCLES = 8,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [15:0]       wantData,
  input  logic [15:0]       readData,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [15:0]       flashData,
  output logic [15:0]       ctrlWord,
  output logic              busy,
  output logic              done
);
  strobe_t stb;
  logic inNeedLo, inNeedHi, keptNeedHi;

  fwp_control #(
    .PGM_MODE_CYCLES(PGM_MODE_CYCLES),
    .PGM_CYCLES(PGM_CYCLES),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .inNeedLo(inNeedLo), .inNeedHi(inNeedHi), .keptNeedHi(keptNeedHi),
    .stb(stb), .busy(busy), .done(done)
  );

  fwp_datapath #(.ADDR_W(ADDR_W), .SEG_N(SEG_N)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .targetAddr(targetAddr), .wantData(wantData), .readData(readData),
    .inNeedLo(inNeedLo), .inNeedHi(inNeedHi), .keptNeedHi(keptNeedHi),
    .flashAddr(flashAddr), .flashData(flashData), .ctrlWord(ctrlWord)
  );
endmodule

// File: rtl/fwp_checker.sv
module fwp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic [15:0] flashData,
  input logic [15:0] ctrlWord
);
  // R1: a pulse never covers bits in both bytes
  p_one_byte_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[15] |-> (flashData[15:8] == 8'hFF || flashData[7:0] == 8'hFF));

  // R6: execute rises together with the key pattern, over a stable mode word
  p_keyed_fire_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlWord[15]) |-> (ctrlWord[13] && !ctrlWord[12] &&
      ctrlWord[9:8] == 2'b10 && $past(ctrlWord[9:0]) == ctrlWord[9:0]));

  // R6: pulse ends by clearing the whole word
  p_full_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlWord[15]) |-> ctrlWord == 16'h0000);

  // R5: mode is set before the pulse, never together with it
  p_mode_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlWord[9]) |-> !ctrlWord[15]);

  // R8: done lasts one cycle and coincides with idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7: control word is zero whenever the block is idle
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> ctrlWord == 16'h0000);
endmodule

bind flash_word_prog fwp_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .flashData(flashData), .ctrlWord(ctrlWord)
);

// File: tb/flash_word_prog_tb.sv
module flash_word_prog_tb;
  localparam int AW = 16;
  localparam int PM = 3;
  localparam int PG = 4;
  localparam int PB = 2;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [15:0] data;
    logic [15:0] ctrl;
    logic busy;
    logic done;
  } snap_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [AW-1:0] targetAddr = '0;
  logic [15:0] wantData = '0, readData = '0;
  logic [AW-1:0] flashAddr;
  logic [15:0] flashData, ctrlWord;
  logic busy, done;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R10";
  snap_t q[$];
  snap_t expS;
  logic [AW-1:0] lastAddr;
  logic [15:0] lastData;

  always #2.5 clk = ~clk;

  flash_word_prog #(.ADDR_W(AW), .SEG_N(8), .PGM_MODE_CYCLES(PM),
    .PGM_CYCLES(PG), .BUSY_CYCLES(PB)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .targetAddr(targetAddr),
    .wantData(wantData), .readData(readData), .flashAddr(flashAddr),
    .flashData(flashData), .ctrlWord(ctrlWord), .busy(busy), .done(done));

  function automatic snap_t mk(logic [AW-1:0] a, logic [15:0] d,
                               logic [15:0] c, logic b, logic dn);
    snap_t s;
    s.addr = a; s.data = d; s.ctrl = c; s.busy = b; s.done = dn;
    return s;
  endfunction

  // Reference plan: expected outputs after each edge, from requirements R2-R8
  task automatic plan(logic [AW-1:0] a, logic [15:0] w, logic [15:0] r);
    logic [15:0] need = r & ~w;
    logic [15:0] modeW = 16'h0200 | (16'h1 << a[AW-1 -: 3]);
    logic [15:0] fireW = modeW | 16'hA000;
    for (int p = 0; p < 2; p++) begin
      logic [7:0] nb = (p == 0) ? need[7:0] : need[15:8];
      logic [15:0] d = (p == 0) ? {8'hFF, ~need[7:0]} : {~need[15:8], 8'hFF};
      if (nb != 8'h00) begin
        lastAddr = a; lastData = d;
        q.push_back(mk(a, d, 16'h0, 1'b1, 1'b0));
        for (int i = 0; i < PM; i++) q.push_back(mk(a, d, modeW, 1'b1, 1'b0));
        for (int i = 0; i < PG; i++) q.push_back(mk(a, d, fireW, 1'b1, 1'b0));
        for (int i = 0; i < PB; i++) q.push_back(mk(a, d, 16'h0, 1'b1, 1'b0));
      end
    end
    q.push_back(mk(lastAddr, lastData, 16'h0, 1'b0, 1'b1));
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      lastAddr = '0; lastData = '0;
      expS = '0;
    end else begin
      if (q.size() == 0 && startReq) plan(targetAddr, wantData, readData);
      if (q.size() != 0) expS = q.pop_front();
      else expS = mk(lastAddr, lastData, 16'h0, 1'b0, 1'b0);
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if ({flashAddr, flashData, ctrlWord, busy, done} !== expS) begin
      errors++;
      $display("FAIL %s (R2/R4/R5/R6/R7/R8 compare) cyc %0d: addr %h data %h ctrl %h busy %b done %b, expected addr %h data %h ctrl %h busy %b done %b",
        tag, cycles, flashAddr, flashData, ctrlWord, busy, done,
        expS.addr, expS.data, expS.ctrl, expS.busy, expS.done);
    end
  end

  task automatic req(logic [AW-1:0] a, logic [15:0] w, logic [15:0] r);
    @(negedge clk);
    targetAddr = a; wantData = w; readData = r; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    targetAddr = ~a; wantData = ~w; readData = '0;
  endtask

  task automatic idleWait();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R10";
    checks++;
    if ({flashAddr, flashData, ctrlWord, busy, done} !== '0) begin
      errors++;
      $display("FAIL R10 reset outputs %h, expected 0",
               {flashAddr, flashData, ctrlWord, busy, done});
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    tag = "R1 R2 both bytes";
    req(16'h2345, 16'h0F30, 16'hFFFF); idleWait();
    tag = "R3 low only";
    req(16'hE010, 16'hFF5A, 16'hFFFF); idleWait();
    tag = "R3 high only, low already set";
    req(16'h7002, 16'h12FF, 16'hF3FF); idleWait();
    tag = "R3 nothing to program";
    req(16'hA000, 16'h1234, 16'h1234); idleWait();
    tag = "R2 already zero bits masked";
    req(16'h4444, 16'h0000, 16'h8001); idleWait();

    // R9: start held high through busy with changing data is ignored
    tag = "R9 start while busy";
    @(negedge clk);
    targetAddr = 16'hC123; wantData = 16'h00FF; readData = 16'hFFFF; startReq = 1'b1;
    @(negedge clk);
    targetAddr = 16'h0001; wantData = 16'h0000; readData = 16'hFFFF;
    repeat (PM + 3) @(negedge clk);
    startReq = 1'b0;
    idleWait();

    // R8: back-to-back request in the done cycle is accepted
    tag = "R8 back to back";
    @(negedge clk);
    targetAddr = 16'h6000; wantData = 16'hFEFE; readData = 16'hFFFF; startReq = 1'b1;
    @(negedge clk);
    while (!done) @(negedge clk);
    targetAddr = 16'h8080; wantData = 16'h7F00; readData = 16'hFFFF;
    @(negedge clk);
    startReq = 1'b0;
    idleWait();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 20000);
    errors++;
    $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule